// File: doc/BRIEF.md
# Key-Protected Frequency Multiplier Configuration Unit

This unit holds the register-side settings of an on-chip clock multiplier. Software writes a control word (enable and connect) and a configuration word (multiplier and post divider) over a simple single-cycle bus. These writes go into pending copies only. The active copies that drive the downstream clock logic change only after software writes a two-word unlock key to a dedicated feed address. The key is 0xAA followed directly by 0x55. This stops a stray store from changing the clock tree.

The oscillator itself lies outside the block. A settle counter stands in for it: the counter runs while the committed enable is active and raises a lock flag after a programmable number of reference cycles. The intended bring-up order has four steps. Software enables the multiplier and feeds the key, then polls the lock flag in the status word. When lock is set, it sets connect and feeds the key again. The connect output stays low until lock is present, even if connect was committed early.

Address map (bus_addr): 0 = control, 1 = configuration, 2 = feed, 3 = status.

Top module: `clkmul_cfg_unit`

## Requirements
- R1: After reset, the pending and active fields are all zero, lock is clear, all outputs are low, and the key tracker waits for its first word.
- R2: A commit copies the pending control and configuration into the active copies. It happens only when a feed write of exactly 0x55 directly follows a feed write of exactly 0xAA. Pending writes alone never change the outputs.
- R3: The key sequence is aborted by any write to a non-feed address between the two key words. It is also aborted by a second feed write with any value other than 0x55, including 0xAA. After an abort, the unit waits again for 0xAA.
- R4: Control bit 0 is enable and bit 1 is connect. So 0x01 commits enable only, and 0x03 commits enable and connect. mul_en follows the active enable.
- R5: Configuration bits 4:0 hold the multiplier minus one, and bits 6:5 select the post divider: 00=1, 01=2, 10=4, 11=8. For example, 0x24 gives mul_factor_m1=4 and post_div_sel=01. Both fields appear on their outputs after commit.
- R6: Lock sets exactly SETTLE_CYCLES clock edges after the edge at which a commit makes the enable active. It stays set while enable is active.
- R7: Lock clears at the same edge that the active enable drops. It also clears at the edge of a commit that changes the multiplier or divider. A commit that leaves both unchanged keeps lock.
- R8: mul_connect is high only while the active connect bit, the active enable and lock are all set.
- R9: Reads of address 0 and 1 return the pending control and configuration, zero-extended. Reads of address 2 return zero. Reads of address 3 return the status word: bits 4:0 active multiplier-minus-one, 6:5 active divider select, 8 active enable, 9 active connect bit, 10 lock, all other bits zero. Writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | 2 | Register address for read and write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| mul_en | output | 1 | Active multiplier enable |
| mul_connect | output | 1 | Gated connect to the CPU clock |
| mul_factor_m1 | output | 5 | Active multiplier minus one |
| post_div_sel | output | 2 | Active post divider select |

## Verification
Directed sequences exercise the bring-up order, each abort path and idempotent recommits. The abort paths are a wrong second word, a repeated 0xAA and an interleaved register write. Recommits separate a lock drop caused by a changed multiplier from a lock kept across an unchanged one. A random mix follows. It combines pending writes, complete keys, corrupted keys, writes to the status and feed addresses, and idle stretches long enough for the settle count to expire. This shows that commits, lock timing and the connect gate stay correct under arbitrary interleavings. Every cycle compares all outputs and the read data of the addressed register against a bench-side model.

// File: rtl/clkmul_pkg.sv
package clkmul_pkg;

    localparam int M_W = 5;
    localparam int P_W = 2;
    localparam int CFG_W = M_W + P_W;

    localparam logic [1:0] ADDR_CTL  = 2'd0;
    localparam logic [1:0] ADDR_CFG  = 2'd1;
    localparam logic [1:0] ADDR_FEED = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;

    localparam int STAT_EN_BIT   = 8;
    localparam int STAT_CONN_BIT = 9;
    localparam int STAT_LOCK_BIT = 10;

    typedef struct packed {
        logic conn;
        logic en;
    } ctl_t;

    typedef struct packed {
        logic [P_W-1:0] div;
        logic [M_W-1:0] m1;
    } cfg_t;

    typedef enum logic {
        KS_IDLE  = 1'b0,
        KS_ARMED = 1'b1
    } key_state_e;

endpackage

// File: rtl/clkmul_key_seq.sv
module clkmul_key_seq
    import clkmul_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              is_feed,
    input  logic [DATA_W-1:0] wdata,
    output logic              commit
);

    localparam logic [DATA_W-1:0] FIRST_W  = DATA_W'(KEY_FIRST);
    localparam logic [DATA_W-1:0] SECOND_W = DATA_W'(KEY_SECOND);

    key_state_e st_d, st_q;

    always_comb begin
        st_d   = st_q;
        commit = 1'b0;
        if (wr) begin
            if (is_feed) begin
                case (st_q)
                    KS_IDLE:  st_d = (wdata == FIRST_W) ? KS_ARMED : KS_IDLE;
                    KS_ARMED: begin
                        st_d   = KS_IDLE;
                        commit = (wdata == SECOND_W);
                    end
                    default:  st_d = KS_IDLE;
                endcase
            end else begin
                st_d = KS_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= KS_IDLE;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/clkmul_stage_regs.sv
module clkmul_stage_regs
    import clkmul_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [1:0]       addr,
    input  logic [CFG_W-1:0] wdata,
    input  logic             commit,
    output ctl_t             pend_ctl,
    output cfg_t             pend_cfg,
    output ctl_t             act_ctl,
    output cfg_t             act_cfg,
    output logic             en_next,
    output logic             restart
);

    typedef struct packed {
        ctl_t pctl;
        cfg_t pcfg;
        ctl_t actl;
        cfg_t acfg;
    } stage_t;

    stage_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr && addr == ADDR_CTL) s_d.pctl = ctl_t'(wdata[1:0]);
        if (wr && addr == ADDR_CFG) s_d.pcfg = cfg_t'(wdata);
        if (commit) begin
            s_d.actl = s_q.pctl;
            s_d.acfg = s_q.pcfg;
        end
        en_next = s_d.actl.en;
        restart = commit && (s_q.pcfg != s_q.acfg);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend_ctl = s_q.pctl;
    assign pend_cfg = s_q.pcfg;
    assign act_ctl  = s_q.actl;
    assign act_cfg  = s_q.acfg;

endmodule

// File: rtl/clkmul_settle.sv
module clkmul_settle #(
    parameter int SETTLE_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_q,
    input  logic en_next,
    input  logic restart,
    output logic lock
);

    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             lock;
    } settle_t;

    settle_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (!en_next || restart) begin
            t_d = '0;
        end else if (en_q && !t_q.lock) begin
            if (t_q.cnt == LAST) t_d.lock = 1'b1;
            else                 t_d.cnt  = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign lock = t_q.lock;

endmodule

// File: rtl/clkmul_cfg_unit.sv
module clkmul_cfg_unit
    import clkmul_pkg::*;
#(
    parameter int DATA_W        = 16,
    parameter int SETTLE_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              mul_en,
    output logic              mul_connect,
    output logic [M_W-1:0]    mul_factor_m1,
    output logic [P_W-1:0]    post_div_sel
);

    ctl_t pend_ctl, act_ctl;
    cfg_t pend_cfg, act_cfg;
    logic commit_w, en_next_w, restart_w, lock_w;
    logic [DATA_W-1:0] status_w;

    clkmul_key_seq #(.DATA_W(DATA_W)) u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .is_feed (bus_addr == ADDR_FEED),
        .wdata   (bus_wdata),
        .commit  (commit_w)
    );

    clkmul_stage_regs u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata[CFG_W-1:0]),
        .commit   (commit_w),
        .pend_ctl (pend_ctl),
        .pend_cfg (pend_cfg),
        .act_ctl  (act_ctl),
        .act_cfg  (act_cfg),
        .en_next  (en_next_w),
        .restart  (restart_w)
    );

    clkmul_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_q    (act_ctl.en),
        .en_next (en_next_w),
        .restart (restart_w),
        .lock    (lock_w)
    );

    always_comb begin
        status_w = '0;
        status_w[CFG_W-1:0]    = act_cfg;
        status_w[STAT_EN_BIT]   = act_ctl.en;
        status_w[STAT_CONN_BIT] = act_ctl.conn;
        status_w[STAT_LOCK_BIT] = lock_w;
    end

    always_comb begin
        case (bus_addr)
            ADDR_CTL:  bus_rdata = DATA_W'(pend_ctl);
            ADDR_CFG:  bus_rdata = DATA_W'(pend_cfg);
            ADDR_STAT: bus_rdata = status_w;
            default:   bus_rdata = '0;
        endcase
    end

    assign mul_en        = act_ctl.en;
    assign mul_connect   = act_ctl.conn & act_ctl.en & lock_w;
    assign mul_factor_m1 = act_cfg.m1;
    assign post_div_sel  = act_cfg.div;

endmodule

// File: rtl/clkmul_cfg_chk.sv
module clkmul_cfg_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              mul_en,
    input logic              mul_connect,
    input logic [4:0]        mul_factor_m1,
    input logic [1:0]        post_div_sel,
    input logic              lock,
    input logic              commit
);

    AST_CONNECT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        mul_connect |-> (mul_en && lock)); // R8

    AST_COMMIT_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (bus_wr && bus_addr == 2'd2 && bus_wdata == DATA_W'(8'h55))); // R2

    AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(mul_en) && $stable(mul_factor_m1) && $stable(post_div_sel))); // R2

    AST_LOCK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> mul_en); // R7

    AST_LOCK_DROPS_WITH_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mul_en) |-> !lock); // R7

    AST_LOCK_RISES_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> $past(mul_en)); // R6

endmodule

bind clkmul_cfg_unit clkmul_cfg_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .mul_en        (mul_en),
    .mul_connect   (mul_connect),
    .mul_factor_m1 (mul_factor_m1),
    .post_div_sel  (post_div_sel),
    .lock          (lock_w),
    .commit        (commit_w)
);

// File: tb/tb_clkmul_cfg_unit.sv
module tb_clkmul_cfg_unit;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 16;
    localparam int SETTLE     = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [1:0]        bus_addr = 2'd3;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              mul_en, mul_connect;
    logic [4:0]        mul_factor_m1;
    logic [1:0]        post_div_sel;

    int n_vec = 0;
    int n_bad = 0;

    clkmul_cfg_unit #(.DATA_W(DATA_W), .SETTLE_CYCLES(SETTLE)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mul_en(mul_en),
        .mul_connect(mul_connect), .mul_factor_m1(mul_factor_m1),
        .post_div_sel(post_div_sel)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // bench-side model of the requirements
    logic       m_armed = 1'b0;
    logic [1:0] m_pctl = '0, m_actl = '0;
    logic [6:0] m_pcfg = '0, m_acfg = '0;
    logic       m_lock = 1'b0;
    int         m_cnt = 0;

    always @(posedge clk) begin
        logic       cm;
        logic [1:0] n_actl;
        logic [6:0] n_acfg;
        if (!rst_n) begin
            m_armed = 0; m_pctl = 0; m_actl = 0; m_pcfg = 0; m_acfg = 0;
            m_lock = 0; m_cnt = 0;
        end else begin
            cm = 1'b0;
            if (bus_wr) begin
                if (bus_addr == 2'd2) begin
                    if (m_armed) begin
                        cm = (bus_wdata == 16'h0055);
                        m_armed = 1'b0;
                    end else begin
                        m_armed = (bus_wdata == 16'h00AA);
                    end
                end else begin
                    m_armed = 1'b0;
                end
            end
            n_actl = cm ? m_pctl : m_actl;
            n_acfg = cm ? m_pcfg : m_acfg;
            if (!n_actl[0] || (cm && m_pcfg != m_acfg)) begin
                m_cnt = 0; m_lock = 0;
            end else if (m_actl[0] && !m_lock) begin
                m_cnt = m_cnt + 1;
                if (m_cnt == SETTLE) m_lock = 1'b1;
            end
            if (bus_wr && bus_addr == 2'd0) m_pctl = bus_wdata[1:0];
            if (bus_wr && bus_addr == 2'd1) m_pcfg = bus_wdata[6:0];
            m_actl = n_actl;
            m_acfg = n_acfg;
        end
    end

    function automatic logic [DATA_W-1:0] exp_rd(input logic [1:0] a);
        logic [DATA_W-1:0] v;
        v = '0;
        case (a)
            2'd0: v[1:0] = m_pctl;
            2'd1: v[6:0] = m_pcfg;
            2'd3: begin
                v[6:0] = m_acfg;
                v[8]   = m_actl[0];
                v[9]   = m_actl[1];
                v[10]  = m_lock;
            end
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        n_vec++;
        chk("R4 mul_en", int'(mul_en), int'(m_actl[0]));
        chk("R2,R3,R5 mul_factor_m1", int'(mul_factor_m1), int'(m_acfg[4:0]));
        chk("R2,R3,R5 post_div_sel", int'(post_div_sel), int'(m_acfg[6:5]));
        chk("R8 mul_connect", int'(mul_connect), int'(m_actl[1] & m_actl[0] & m_lock));
        chk("R9 bus_rdata", int'(bus_rdata), int'(exp_rd(bus_addr)));
        if (bus_addr == 2'd3)
            chk("R6,R7 lock flag", int'(bus_rdata[10]), int'(m_lock));
    endtask

    task automatic step(input logic wr, input logic [1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        compare_all();
        bus_wr = wr; bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle(input int n, input logic [1:0] a);
        for (int i = 0; i < n; i++) step(1'b0, a, '0);
    endtask

    task automatic feed(input logic [DATA_W-1:0] k1, input logic [DATA_W-1:0] k2);
        step(1'b1, 2'd2, k1);
        step(1'b1, 2'd2, k2);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        @(negedge clk);
        chk("R1 reset status", int'(bus_rdata), 0);
        chk("R1 reset outputs", int'({mul_en, mul_connect, mul_factor_m1, post_div_sel}), 0);

        // R4 R5: enable only, multiplier 5 divider 2; pending alone has no effect (R2)
        step(1'b1, 2'd0, 16'h0001);
        step(1'b1, 2'd1, 16'h0024);
        idle(3, 2'd3);
        feed(16'h00AA, 16'h0055);
        step(1'b0, 2'd3, '0);
        @(negedge clk);
        chk("R5 mult field from 0x24", int'(mul_factor_m1), 4);
        chk("R5 divider select from 0x24", int'(post_div_sel), 1);
        // R6: wait for lock
        idle(SETTLE + 2, 2'd3);
        chk("R6 lock after settle", int'(bus_rdata[10]), 1);
        // R8: connect committed with lock present
        step(1'b1, 2'd0, 16'h0003);
        feed(16'h00AA, 16'h0055);
        idle(2, 2'd3);
        chk("R8 connect asserted", int'(mul_connect), 1);

        // R3: abort paths
        step(1'b1, 2'd1, 16'h0063);
        step(1'b1, 2'd2, 16'h00AA);
        step(1'b1, 2'd0, 16'h0003);
        step(1'b1, 2'd2, 16'h0055);
        feed(16'h00AA, 16'h00AA);
        step(1'b1, 2'd2, 16'h0055);
        feed(16'h00AA, 16'h0012);
        step(1'b1, 2'd2, 16'h0055);
        feed(16'h01AA, 16'h0055);
        idle(2, 2'd3);
        chk("R3 no commit after aborts", int'(mul_factor_m1), 4);

        // R9: write to status ignored, feed reads zero
        step(1'b1, 2'd3, 16'hFFFF);
        idle(2, 2'd2);
        idle(2, 2'd3);

        // R7: same cfg recommit keeps lock, changed cfg drops it
        step(1'b1, 2'd1, 16'h0024);
        feed(16'h00AA, 16'h0055);
        idle(2, 2'd3);
        chk("R7 lock kept on same cfg", int'(bus_rdata[10]), 1);
        step(1'b1, 2'd1, 16'h0063);
        feed(16'h00AA, 16'h0055);
        idle(1, 2'd3);
        chk("R7 lock dropped on new cfg", int'(bus_rdata[10]), 0);
        chk("R8 connect held off without lock", int'(mul_connect), 0);
        idle(SETTLE + 2, 2'd3);
        step(1'b1, 2'd0, 16'h0002);
        feed(16'h00AA, 16'h0055);
        idle(1, 2'd3);
        chk("R7 lock dropped with enable", int'(bus_rdata[10]), 0);

        // random mix
        for (int it = 0; it < 2500; it++) begin
            int r;
            r = int'($urandom % 10);
            case (r)
                0, 1: step(1'b1, 2'd0, DATA_W'($urandom % 4));
                2, 3: step(1'b1, 2'd1, DATA_W'($urandom % 128));
                4, 5, 6: begin
                    if ($urandom % 4 == 0) feed(16'h00AA, DATA_W'($urandom % 256));
                    else                   feed(16'h00AA, 16'h0055);
                end
                7: step(1'b1, 2'(2 + $urandom % 2), DATA_W'($urandom));
                default: idle(1 + int'($urandom % 20), 2'($urandom % 4));
            endcase
        end
        idle(2, 2'd3);
        finish_run();
    end

endmodule